// File: doc/BRIEF.md
# Programmable Serial Bit-Clock Divider

This block derives the oversampling clock for a serial receiver or transmitter from the system clock. Software writes one 32-bit control word. The word holds an enable flag, a select for a fixed coarse divider, and a 12-bit reload value. The block counts system clock cycles, optionally through the coarse divider first. It emits a one-cycle pulse every (reload+1) counted steps. The rate is set so that the pulse train runs at sixteen times the wanted bit rate. The same events drive a square-wave output at half the pulse rate.

The reload value is the wanted divide ratio minus one. Very slow rates that do not fit in 12 bits use the coarse divider, which multiplies the period by sixteen. Every write restarts the divider chain from a clean state, so no count is left over from an earlier setting. Clearing the enable flag parks the whole chain with both outputs low.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick_o`, `sqw_o` and `cfg_rdata` are all zero.
- R2: A write stores only three fields. Bit 16 is the enable, bit 0 selects the coarse divide-by-16 stage, and bits [12:1] hold the 12-bit reload value D. `cfg_rdata` returns those bits from the cycle after the write, and every other bit reads as zero.
- R3: With enable set and the coarse stage off, the first `tick_o` pulse is high in the (D+1)-th cycle after the write edge. Later pulses repeat every D+1 cycles.
- R4: With the coarse stage selected, the first pulse and the repeat period both become 16*(D+1) cycles.
- R5: For D greater than zero, `tick_o` is high for exactly one cycle. For D equal to zero, `tick_o` stays high in every cycle.
- R6: `sqw_o` is low right after any write. It then inverts on every pulse, giving a 50% duty clock at half the pulse rate.
- R7: While enable is clear, `tick_o` and `sqw_o` stay low. A write that clears enable drives both low from the next cycle.
- R8: A write during a count discards the old count. The timing of R3/R4 restarts from that write's edge with the new value.
- R9: Both ends of the reload range work. D=0 gives a period of one cycle, and D=4095 gives a period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every cycle is one input step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 32 | Control word to store |
| cfg_rdata | output | 32 | Stored control word with unused bits zero |
| tick_o | output | 1 | One-cycle pulse at 16x the bit rate |
| sqw_o | output | 1 | Square wave toggled by each pulse |

## Verification
The bench builds the block with its default parameters: a 12-bit reload field, a coarse stage of 2^4, and the enable at bit 16. With these values the largest reload of 4095 is reachable without the coarse stage, in about four thousand cycles. The coarse stage is exercised with a small reload, so its 16x scaling shows in a few dozen cycles. Both ends of the reload range can therefore be measured exactly within a short run. The bench also covers a restart in the middle of a long count.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned PRE_POS = 0;
  localparam int unsigned DIV_LSB = 1;

  // Bits that hold state in the control word; all others read as zero.
  function automatic logic [CTRL_W-1:0] ctrl_mask(int unsigned en_pos, int unsigned div_w);
    logic [CTRL_W-1:0] m;
    m = '0;
    m[PRE_POS] = 1'b1;
    for (int i = 0; i < int'(div_w); i++) m[DIV_LSB + i] = 1'b1;
    m[en_pos] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
#(
  parameter int unsigned EN_POS = 16,
  parameter int unsigned DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] word_q,
  output logic              run,
  output logic              pre_sel,
  output logic [DIV_W-1:0]  div,
  output logic              ld,
  output logic              ld_run,
  output logic              ld_pre,
  output logic [DIV_W-1:0]  ld_div
);
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask(EN_POS, DIV_W);

  logic [CTRL_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (wr_en) word_d = wr_data & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  // Values that take effect at the write edge, used to restart the chain.
  assign ld      = wr_en;
  assign ld_run  = wr_data[EN_POS];
  assign ld_pre  = wr_data[PRE_POS];
  assign ld_div  = wr_data[DIV_LSB +: DIV_W];

  assign run     = word_q[EN_POS];
  assign pre_sel = word_q[PRE_POS];
  assign div     = word_q[DIV_LSB +: DIV_W];

  // R2: readback follows the last write, masked to the live fields
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> word_q == ($past(wr_data) & MASK));
endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int unsigned PRE_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic run,
  input  logic pre_sel,
  output logic strobe
);
  generate
    if (PRE_LOG2 == 0) begin : g_bypass
      assign strobe = run;
    end else begin : g_phase
      localparam logic [PRE_LOG2-1:0] PH_LAST = '1;
      logic [PRE_LOG2-1:0] ph_q, ph_d;

      always_comb begin
        ph_d = ph_q;
        if (ld || !run || !pre_sel) ph_d = '0;
        else                        ph_d = ph_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
      end

      assign strobe = run && (!pre_sel || ph_q == PH_LAST);

      // R4/R7: phase rests at zero unless the coarse stage is running
      assert_phase_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !pre_sel) |-> ph_q == '0);
      // R4: with the coarse stage, steps never come back to back
      assert_coarse_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && pre_sel) |=> !strobe);
    end
  endgenerate
endmodule

// File: rtl/brg_divcnt.sv
module brg_divcnt #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             ld_run,
  input  logic [DIV_W-1:0] ld_div,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             strobe,
  output logic             tick_q,
  output logic             sqw_q
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_d, sqw_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    sqw_d  = sqw_q;
    if (ld) begin
      cnt_d = ld_run ? ld_div : '0;
      sqw_d = 1'b0;
    end else if (!run) begin
      cnt_d = '0;
      sqw_d = 1'b0;
    end else if (strobe) begin
      if (cnt_q == '0) begin
        cnt_d  = div;
        tick_d = 1'b1;
        sqw_d  = !sqw_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      sqw_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
      sqw_q  <= sqw_d;
    end
  end

  // R9: the count never exceeds the programmed reload value
  assert_cnt_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= div);
  // R7: no pulse while disabled
  assert_tick_only_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> run);
  // R5: nonzero reload gives a single-cycle pulse
  assert_tick_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && div != '0) |=> !tick_q);
  // R6: the square wave only rises together with a pulse
  assert_sqw_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqw_q) |-> tick_q);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import brg_pkg::*;
#(
  parameter int unsigned DIV_W    = 12,
  parameter int unsigned PRE_LOG2 = 4,
  parameter int unsigned EN_POS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              tick_o,
  output logic              sqw_o
);
  logic             run, pre_sel, ld, ld_run, ld_pre, strobe;
  logic [DIV_W-1:0] div, ld_div;

  brg_ctrl #(.EN_POS(EN_POS), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .word_q(cfg_rdata), .run(run), .pre_sel(pre_sel), .div(div),
    .ld(ld), .ld_run(ld_run), .ld_pre(ld_pre), .ld_div(ld_div)
  );

  brg_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .ld(ld), .run(run), .pre_sel(pre_sel),
    .strobe(strobe)
  );

  brg_divcnt #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_run(ld_run), .ld_div(ld_div),
    .run(run), .div(div), .strobe(strobe), .tick_q(tick_o), .sqw_q(sqw_o)
  );

  // R6: outputs are cleared on the edge after any write
  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!tick_o && !sqw_o));

  logic unused_ld_pre;
  assign unused_ld_pre = ld_pre;
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        tick_o, sqw_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tick_o(tick_o), .sqw_o(sqw_o)
  );

  localparam logic [31:0] EN  = 32'h0001_0000;
  localparam logic [31:0] PRE = 32'h0000_0001;

  function automatic logic [31:0] dv(int d);
    return 32'(d) << 1;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      summary_and_end();
    end
  end

  // Write lands on the next rising edge; returns just after that edge.
  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic edges_to_tick(output int k);
    k = 0;
    do begin
      @(posedge clk);
      #1;
      k++;
    end while (!tick_o && k < 70000);
  endtask

  // Measure first pulse, width, period and square-wave phase after a write.
  task automatic measure(input int first, input int period, input string req);
    int k;
    check(sqw_o == 1'b0, {req, "/R6 sqw low after write"}, sqw_o, 0);
    edges_to_tick(k);
    check(k == first, {req, " first pulse"}, k, first);
    check(sqw_o == 1'b1, {req, "/R6 sqw after pulse 1"}, sqw_o, 1);
    if (period > 1) begin
      @(posedge clk);
      #1;
      check(tick_o == 1'b0, {req, "/R5 pulse width"}, tick_o, 0);
      edges_to_tick(k);
      k++;
    end else begin
      edges_to_tick(k);
    end
    check(k == period, {req, " period"}, k, period);
    check(sqw_o == 1'b0, {req, "/R6 sqw after pulse 2"}, sqw_o, 0);
  endtask

  task automatic t_reset();
    check(tick_o == 1'b0, "R1 tick", tick_o, 0);
    check(sqw_o == 1'b0, "R1 sqw", sqw_o, 0);
    check(cfg_rdata == 32'h0, "R1 rdata", cfg_rdata, 0);
  endtask

  task automatic t_readback();
    wr(32'hFFFF_FFFF);
    check(cfg_rdata == 32'h0001_1FFF, "R2 mask all-ones", cfg_rdata, 32'h0001_1FFF);
    wr(32'hA5A5_5A5A);
    check(cfg_rdata == 32'h0001_1A5A, "R2 mask pattern", cfg_rdata, 32'h0001_1A5A);
  endtask

  task automatic t_plain();
    wr(EN | dv(5));
    measure(6, 6, "R3 D=5");
    wr(EN | dv(1));
    measure(2, 2, "R3 D=1");
  endtask

  task automatic t_extremes();
    wr(EN | dv(0));
    measure(1, 1, "R9/R5 D=0");
    wr(EN | dv(4095));
    measure(4096, 4096, "R9 D=4095");
  endtask

  task automatic t_coarse();
    wr(EN | PRE | dv(2));
    measure(48, 48, "R4 D=2");
    wr(EN | PRE | dv(0));
    measure(16, 16, "R4 D=0");
  endtask

  task automatic t_reload();
    wr(EN | dv(50));
    repeat (20) @(posedge clk);
    wr(EN | dv(3));
    measure(4, 4, "R8 reload");
  endtask

  task automatic t_disabled();
    int bad = 0;
    wr(EN | dv(1));
    repeat (3) @(posedge clk);
    wr(dv(50));
    check(!tick_o && !sqw_o, "R7 outputs low after disable write", {tick_o, sqw_o}, 0);
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      #1;
      if (tick_o || sqw_o) bad++;
    end
    check(bad == 0, "R7 no activity while disabled", bad, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_readback();
    t_plain();
    t_extremes();
    t_coarse();
    t_reload();
    t_disabled();
    summary_and_end();
  end
endmodule